// File: doc/BRIEF.md
# Frame Trigger and Sequence Controller

This block sets the frame cadence for a group of synchronised acquisition subsystems. Each clock cycle is one tick of the timebase. A single counter divides the ticks into address-return-to-zero (ARZ) periods. Each period is `row_len × num_rows` ticks long, with a floor of 250. On certain ARZ strobes the block also issues a data-valid (DV) frame. Each DV carries a 32-bit frame sequence number, a mode flag and an overrun-error flag. Serializers further downstream turn these into line encodings.

Two modes decide which ARZ carries a DV. In free-run, the block counts ARZs and issues a DV on every `data_rate`-th one. In triggered mode, the block watches an asynchronous active-low request line. After a two-flop synchroniser, a falling edge arms a DV for the next ARZ. Any further edges in the same ARZ interval fold into that single DV and mark it as an overrun.

A trigger state machine holds four states:
- `ST_FREE` is free-run.
- `ST_IDLE` is triggered with no edge pending.
- `ST_ARMED` means one edge is pending.
- `ST_OVERRUN` means more than one edge is pending.

Its transitions are:
- mode set: `ST_FREE`→`ST_IDLE`.
- mode clear: any state→`ST_FREE`.
- edge: `ST_IDLE`→`ST_ARMED`.
- second edge: `ST_ARMED`→`ST_OVERRUN`.
- ARZ: `ST_ARMED`/`ST_OVERRUN`→`ST_IDLE`, or →`ST_ARMED` when an edge lands in the same cycle as the ARZ.

Top module: `frame_sync_ctrl`

## Requirements
- R1: `arz_o` is a one-cycle pulse. Its period is max(row_len × num_rows, 250) cycles. After reset or a restart, the first `arz_o` comes exactly one period after the counting origin.
- R2: Written values are clamped. A value of 0 for row length, row count or data rate becomes 1. Values above the field maximum (4095, 63, 4095) saturate to that maximum. A product below 250 gives a period of 250.
- R3: In free-run, `dv_o` rises together with `arz_o` on every data_rate-th ARZ. The first DV after a restart falls on the data_rate-th ARZ.
- R4: In triggered mode (`free_o` low), a falling edge on `trig_n` gives `dv_o` on the next ARZ. An ARZ with no edge since the previous ARZ gives no DV. data_rate has no effect in this mode.
- R5: When two or more falling edges arrive in one ARZ interval in triggered mode, exactly one DV is issued with `dv_err_o` high. `err_flag_o` goes high after the second edge and is low in the cycle in which `arz_o` is high.
- R6: In free-run, `free_o` is high and `trig_n` is ignored: `err_flag_o` and `dv_err_o` stay low and the DV cadence is unchanged.
- R7: `seq_o` holds the number stamped on the current DV. Consecutive DVs carry consecutive numbers modulo 2^32. After reset the first DV carries 0.
- R8: Writing a sequence preset makes the next DV carry the preset value. Any value from 0 to 2^32−1 is accepted.
- R9: With output enable cleared, `arz_o` and `dv_o` stay low and the sequence number does not advance. Setting the enable again resumes both, and the next DV carries the number after the last one issued.
- R10: A write to row length, row count or data rate restarts the ARZ and data-rate counters. The next ARZ comes one full new period after the write edge, regardless of how far the old period had run.
- R11: After reset the block is in free-run with outputs enabled, row length 50, row count 33 and data rate 38. The first ARZ is at cycle 1650 and the first DV at the 38th ARZ.
- R12: The write port decodes `wr_addr` as follows:
  - 0: row length.
  - 1: row count.
  - 2: data rate.
  - 3: mode, where `wr_data[0]`=1 selects triggered.
  - 4: sequence preset, the full 32 bits.
  - 5: output enable, where `wr_data[0]`=1 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R12) |
| wr_data | input | 32 | Register write data |
| trig_n | input | 1 | Asynchronous active-low frame request |
| arz_o | output | 1 | ARZ strobe, one cycle |
| dv_o | output | 1 | DV strobe, coincident with an ARZ |
| dv_err_o | output | 1 | Overrun mark carried with the DV |
| err_flag_o | output | 1 | Overrun level, cleared at the next ARZ |
| free_o | output | 1 | High in free-run mode |
| seq_o | output | 32 | Sequence number of the latest DV |

## Verification
The bench measures the first ARZ after each restart to the exact cycle, including register settings that must be clamped. A design that used the raw product, or let a zero through, would be early or would stall. It writes a timing register again in the middle of a period. A block that kept the old count would issue an ARZ about 100 cycles early. In triggered mode it checks three intervals in turn: one with no edge, one with a single edge and one with a double edge. Counting edges instead of collapsing them, or failing to clear the overrun at the ARZ, shows up as a wrong `dv_o`, `dv_err_o` or `err_flag_o`. It also presets the sequence number to all ones to catch a missing wrap, and it gates the outputs off to catch a sequence number that advances while DVs are hidden.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int unsigned ADDR_W = 3;

    // register addresses decoded on the write port
    typedef enum logic [ADDR_W-1:0] {
        A_ROWLEN = 3'd0,
        A_NROWS  = 3'd1,
        A_RATE   = 3'd2,
        A_MODE   = 3'd3,
        A_SEQ    = 3'd4,
        A_ENABLE = 3'd5
    } reg_addr_e;

    // trigger arbitration states
    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_IDLE    = 2'd1,
        ST_ARMED   = 2'd2,
        ST_OVERRUN = 2'd3
    } trig_state_e;

endpackage

// File: rtl/fsc_regs.sv
module fsc_regs
    import fsc_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RL_W     = 12,
    parameter int unsigned NR_W     = 6,
    parameter int unsigned RATE_W   = 12,
    parameter int unsigned SEQ_W    = 32,
    parameter int unsigned RL_DEF   = 50,
    parameter int unsigned NR_DEF   = 33,
    parameter int unsigned RATE_DEF = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RL_W-1:0]   row_len,
    output logic [NR_W-1:0]   num_rows,
    output logic [RATE_W-1:0] rate,
    output logic              trig_mode,
    output logic              out_en,
    output logic              restart,
    output logic              seq_load,
    output logic [SEQ_W-1:0]  seq_value
);

    localparam logic [DATA_W-1:0] RL_MAX   = DATA_W'((64'd1 << RL_W) - 64'd1);
    localparam logic [DATA_W-1:0] NR_MAX   = DATA_W'((64'd1 << NR_W) - 64'd1);
    localparam logic [DATA_W-1:0] RATE_MAX = DATA_W'((64'd1 << RATE_W) - 64'd1);

    // zero becomes one, oversize saturates at the field maximum
    function automatic logic [DATA_W-1:0] clamp_field(
        input logic [DATA_W-1:0] v,
        input logic [DATA_W-1:0] hi
    );
        if (v == '0)
            return DATA_W'(1);
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_len   <= RL_W'(RL_DEF);
            num_rows  <= NR_W'(NR_DEF);
            rate      <= RATE_W'(RATE_DEF);
            trig_mode <= 1'b0;
            out_en    <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                A_ROWLEN: row_len   <= RL_W'(clamp_field(wr_data, RL_MAX));
                A_NROWS:  num_rows  <= NR_W'(clamp_field(wr_data, NR_MAX));
                A_RATE:   rate      <= RATE_W'(clamp_field(wr_data, RATE_MAX));
                A_MODE:   trig_mode <= wr_data[0];
                A_ENABLE: out_en    <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // any timing field write restarts the period counters
    assign restart   = wr_en && ((wr_addr == A_ROWLEN) ||
                                 (wr_addr == A_NROWS)  ||
                                 (wr_addr == A_RATE));
    assign seq_load  = wr_en && (wr_addr == A_SEQ);
    assign seq_value = SEQ_W'(wr_data);

endmodule

// File: rtl/fsc_timebase.sv
module fsc_timebase #(
    parameter int unsigned RL_W       = 12,
    parameter int unsigned NR_W       = 6,
    parameter int unsigned RATE_W     = 12,
    parameter int unsigned MIN_PERIOD = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RL_W-1:0]   row_len,
    input  logic [NR_W-1:0]   num_rows,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    input  logic              hold_rate,
    output logic              arz_tick,
    output logic              rate_hit
);

    localparam int unsigned PER_W = RL_W + NR_W;

    logic [PER_W-1:0]  product;
    logic [PER_W-1:0]  period;
    logic [PER_W-1:0]  cnt_q;
    logic [RATE_W-1:0] rate_cnt_q;

    assign product  = PER_W'(row_len) * PER_W'(num_rows);
    assign period   = (product < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : product;
    assign arz_tick = (cnt_q >= (period - PER_W'(1))) && !restart;
    assign rate_hit = (rate_cnt_q >= (rate - RATE_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || arz_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rate_cnt_q <= '0;
        else if (restart || hold_rate)
            rate_cnt_q <= '0;
        else if (arz_tick)
            rate_cnt_q <= rate_hit ? '0 : rate_cnt_q + RATE_W'(1);
    end

endmodule

// File: rtl/fsc_trig_sync.sv
module fsc_trig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n_async,
    output logic trig_fall
);

    // stages 0..STAGES-1 synchronise, stage STAGES holds the previous sample
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shift_q <= '1;
        else
            shift_q <= {shift_q[STAGES-1:0], trig_n_async};
    end

    assign trig_fall = shift_q[STAGES] & ~shift_q[STAGES-1];

endmodule

// File: rtl/fsc_frame_fsm.sv
module fsc_frame_fsm
    import fsc_pkg::*;
#(
    parameter int unsigned SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arz_tick,
    input  logic             rate_hit,
    input  logic             trig_fall,
    input  logic             trig_mode,
    input  logic             out_en,
    input  logic             seq_load,
    input  logic [SEQ_W-1:0] seq_value,
    output logic             arz_o,
    output logic             dv_o,
    output logic             dv_err_o,
    output logic             err_flag_o,
    output logic             free_o,
    output logic [SEQ_W-1:0] seq_o
);

    trig_state_e      state_q, state_d;
    logic             fire;
    logic             fire_ok;
    logic [SEQ_W-1:0] seq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FREE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (trig_mode)
                    state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!trig_mode)
                    state_d = ST_FREE;
                else if (trig_fall)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!trig_mode)
                    state_d = ST_FREE;
                else if (arz_tick)
                    state_d = trig_fall ? ST_ARMED : ST_IDLE;
                else if (trig_fall)
                    state_d = ST_OVERRUN;
            end
            ST_OVERRUN: begin
                if (!trig_mode)
                    state_d = ST_FREE;
                else if (arz_tick)
                    state_d = trig_fall ? ST_ARMED : ST_IDLE;
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_FREE:              fire = arz_tick && rate_hit;
            ST_ARMED, ST_OVERRUN: fire = arz_tick;
            default:              fire = 1'b0;
        endcase
    end

    assign fire_ok = fire && out_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else if (seq_load)
            seq_q <= seq_value;
        else if (fire_ok)
            seq_q <= seq_q + SEQ_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arz_o    <= 1'b0;
            dv_o     <= 1'b0;
            dv_err_o <= 1'b0;
            seq_o    <= '0;
        end else begin
            arz_o    <= arz_tick && out_en;
            dv_o     <= fire_ok;
            dv_err_o <= fire_ok && (state_q == ST_OVERRUN);
            if (fire_ok)
                seq_o <= seq_q;
        end
    end

    assign err_flag_o = (state_q == ST_OVERRUN);
    assign free_o     = (state_q == ST_FREE);

endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned RL_W        = 12,
    parameter int unsigned NR_W        = 6,
    parameter int unsigned RATE_W      = 12,
    parameter int unsigned SEQ_W       = 32,
    parameter int unsigned MIN_PERIOD  = 250,
    parameter int unsigned RL_DEF      = 50,
    parameter int unsigned NR_DEF      = 33,
    parameter int unsigned RATE_DEF    = 38,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig_n,
    output logic              arz_o,
    output logic              dv_o,
    output logic              dv_err_o,
    output logic              err_flag_o,
    output logic              free_o,
    output logic [SEQ_W-1:0]  seq_o
);

    logic [RL_W-1:0]   row_len;
    logic [NR_W-1:0]   num_rows;
    logic [RATE_W-1:0] rate;
    logic              trig_mode;
    logic              out_en;
    logic              restart;
    logic              seq_load;
    logic [SEQ_W-1:0]  seq_value;
    logic              arz_tick;
    logic              rate_hit;
    logic              trig_fall;

    fsc_regs #(
        .DATA_W(DATA_W), .RL_W(RL_W), .NR_W(NR_W), .RATE_W(RATE_W), .SEQ_W(SEQ_W),
        .RL_DEF(RL_DEF), .NR_DEF(NR_DEF), .RATE_DEF(RATE_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .row_len(row_len), .num_rows(num_rows), .rate(rate),
        .trig_mode(trig_mode), .out_en(out_en), .restart(restart),
        .seq_load(seq_load), .seq_value(seq_value)
    );

    fsc_timebase #(
        .RL_W(RL_W), .NR_W(NR_W), .RATE_W(RATE_W), .MIN_PERIOD(MIN_PERIOD)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .row_len(row_len), .num_rows(num_rows),
        .rate(rate), .restart(restart), .hold_rate(trig_mode),
        .arz_tick(arz_tick), .rate_hit(rate_hit)
    );

    fsc_trig_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_n_async(trig_n), .trig_fall(trig_fall)
    );

    fsc_frame_fsm #(
        .SEQ_W(SEQ_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .arz_tick(arz_tick), .rate_hit(rate_hit),
        .trig_fall(trig_fall), .trig_mode(trig_mode), .out_en(out_en),
        .seq_load(seq_load), .seq_value(seq_value),
        .arz_o(arz_o), .dv_o(dv_o), .dv_err_o(dv_err_o),
        .err_flag_o(err_flag_o), .free_o(free_o), .seq_o(seq_o)
    );

endmodule

// File: rtl/frame_sync_ctrl_chk.sv
module frame_sync_ctrl_chk #(
    parameter int unsigned MIN_PERIOD = 250,
    parameter int unsigned SEQ_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             wr_bit0,
    input logic             arz_o,
    input logic             dv_o,
    input logic             dv_err_o,
    input logic             err_flag_o,
    input logic             free_o,
    input logic [SEQ_W-1:0] seq_o
);

    logic [31:0]      gap_q;
    logic             seen_q;
    logic [SEQ_W-1:0] last_seq_q;
    logic             have_last_q;
    logic             preset_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (arz_o) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_seq_q    <= '0;
            have_last_q   <= 1'b0;
            preset_seen_q <= 1'b0;
        end else begin
            if (dv_o) begin
                last_seq_q    <= seq_o;
                have_last_q   <= 1'b1;
                preset_seen_q <= 1'b0;
            end
            if (wr_en && (wr_addr == 3'd4))
                preset_seen_q <= 1'b1;
        end
    end

    p_arz_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (arz_o && seen_q) |-> (gap_q >= MIN_PERIOD));

    p_dv_on_arz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |-> arz_o);

    p_err_with_dv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dv_err_o |-> dv_o);

    p_err_clear_at_arz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arz_o |-> !err_flag_o);

    p_free_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o && $past(free_o)) |-> !dv_err_o);

    p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_o && have_last_q && !preset_seen_q) |-> (seq_o == last_seq_q + SEQ_W'(1)));

    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 3'd5) && !wr_bit0) |-> ##2 (!arz_o && !dv_o));

endmodule

bind frame_sync_ctrl frame_sync_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]),
    .arz_o(arz_o), .dv_o(dv_o), .dv_err_o(dv_err_o), .err_flag_o(err_flag_o),
    .free_o(free_o), .seq_o(seq_o)
);

// File: tb/frame_sync_ctrl_tb.sv
module frame_sync_ctrl_tb;

    localparam logic [2:0] A_RL = 3'd0, A_NR = 3'd1, A_RATE = 3'd2,
                           A_MODE = 3'd3, A_SEQ = 3'd4, A_EN = 3'd5;

    localparam int NV = 6;
    localparam logic [31:0] V_RL   [NV] = '{32'd10, 32'd1, 32'd0, 32'd20, 32'd5000, 32'd13};
    localparam logic [31:0] V_NR   [NV] = '{32'd25, 32'd1, 32'd0, 32'd15, 32'd1, 32'd40};
    localparam logic [31:0] V_RATE [NV] = '{32'd2, 32'd1, 32'd0, 32'd3, 32'd2, 32'd1};
    localparam int          V_PER  [NV] = '{250, 250, 250, 300, 4095, 520};
    localparam int          V_DVN  [NV] = '{2, 1, 1, 3, 2, 1};
    localparam logic [31:0] V_SEQ  [NV] = '{32'd100, 32'hFFFF_FFFF, 32'd7, 32'd0, 32'h1234_5678, 32'd55};
    localparam bit          V_TOG  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        trig_n = 1'b1;
    logic        arz_o, dv_o, dv_err_o, err_flag_o, free_o;
    logic [31:0] seq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_sync_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_n(trig_n), .arz_o(arz_o), .dv_o(dv_o), .dv_err_o(dv_err_o),
        .err_flag_o(err_flag_o), .free_o(free_o), .seq_o(seq_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // n = negedges stepped until the chosen strobe is seen
    task automatic wait_sig(input bit use_dv, input bit now, input int limit, output int n);
        n = 0;
        if (!now) begin
            @(negedge clk);
            n = 1;
        end
        while (!(use_dv ? dv_o : arz_o) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    // each pulse takes 9 negedges
    task automatic pulse_trig(input int count);
        repeat (count) begin
            @(negedge clk);
            trig_n = 1'b0;
            repeat (4) @(negedge clk);
            trig_n = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, idx, cnt;
        logic [31:0] s0;

        // ---- reset defaults (R11)
        repeat (3) @(negedge clk);
        chk("R11", "arz during reset", arz_o, 0);
        rst_n = 1'b1;
        chk("R11", "free_o after reset", free_o, 1);
        chk("R11", "seq_o after reset", seq_o, 0);
        chk("R11", "err_flag after reset", err_flag_o, 0);
        chk("R11", "dv after reset", dv_o, 0);
        wait_sig(1'b0, 1'b1, 5000, n);
        chk("R11", "first ARZ cycle", n, 1650);
        idx = 1;
        while (!dv_o && idx < 60) begin
            wait_sig(1'b0, 1'b0, 5000, n);
            idx++;
        end
        chk("R11", "default data rate ARZ index", idx, 38);
        chk("R7", "first frame number", seq_o, 0);

        // ---- table of free-run settings (R1 R2 R3 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            int gap;
            wr_reg(A_RL, V_RL[i]);
            wr_reg(A_SEQ, V_SEQ[i]);
            wr_reg(A_NR, V_NR[i]);
            wr_reg(A_RATE, V_RATE[i]);
            wait_sig(1'b0, 1'b1, 5000, n);
            chk("R1 R2", $sformatf("vec %0d period", i), n, V_PER[i]);
            idx = 1;
            while (!dv_o && idx < 20) begin
                wait_sig(1'b0, 1'b0, 5000, n);
                idx++;
            end
            chk("R3", $sformatf("vec %0d first DV ARZ index", i), idx, V_DVN[i]);
            chk("R8", $sformatf("vec %0d preset stamp", i), seq_o, V_SEQ[i]);
            chk("R6", $sformatf("vec %0d free_o", i), free_o, 1);
            gap = 0;
            if (V_TOG[i]) begin
                pulse_trig(3);
                gap = 27;
                chk("R6", $sformatf("vec %0d err_flag after edges", i), err_flag_o, 0);
            end
            wait_sig(1'b1, 1'b0, 20000, n);
            gap += n;
            chk("R3", $sformatf("vec %0d DV spacing", i), gap, V_PER[i] * V_DVN[i]);
            s0 = V_SEQ[i] + 32'd1;
            chk("R7", $sformatf("vec %0d next stamp", i), seq_o, s0);
            chk("R6", $sformatf("vec %0d dv_err", i), dv_err_o, 0);
        end

        // ---- triggered mode (R4 R5 R12)
        wr_reg(A_MODE, 32'd1);
        wr_reg(A_RL, 32'd10);
        wr_reg(A_NR, 32'd25);
        wr_reg(A_RATE, 32'd5);
        chk("R12", "mode bit selects triggered", free_o, 0);
        wait_sig(1'b0, 1'b1, 1000, n);
        chk("R1", "triggered ARZ period", n, 250);
        chk("R4", "no edge no DV", dv_o, 0);
        pulse_trig(1);
        wait_sig(1'b0, 1'b0, 1000, n);
        chk("R4", "single edge DV", dv_o, 1);
        chk("R4", "single edge no overrun", dv_err_o, 0);
        s0 = seq_o;
        pulse_trig(2);
        chk("R5", "err_flag after two edges", err_flag_o, 1);
        wait_sig(1'b0, 1'b0, 1000, n);
        chk("R5", "double edge one DV", dv_o, 1);
        chk("R5", "double edge overrun mark", dv_err_o, 1);
        chk("R5", "err_flag cleared at ARZ", err_flag_o, 0);
        chk("R7", "triggered stamp step", seq_o, s0 + 32'd1);
        wait_sig(1'b0, 1'b0, 1000, n);
        chk("R4", "quiet interval no DV", dv_o, 0);
        chk("R5", "no overrun mark after quiet", dv_err_o, 0);

        // ---- back to free-run, edges ignored (R6)
        wr_reg(A_MODE, 32'd0);
        pulse_trig(2);
        chk("R6", "free_o after mode clear", free_o, 1);
        chk("R6", "err_flag stays low", err_flag_o, 0);

        // ---- output enable (R9)
        wr_reg(A_RATE, 32'd1);
        wait_sig(1'b1, 1'b1, 1000, n);
        s0 = seq_o;
        wr_reg(A_EN, 32'd0);
        cnt = 0;
        repeat (600) begin
            @(negedge clk);
            if (arz_o || dv_o) cnt++;
        end
        chk("R9", "strobes while disabled", cnt, 0);
        wr_reg(A_EN, 32'd1);
        wait_sig(1'b1, 1'b0, 1000, n);
        chk("R9", "DV resumes", dv_o, 1);
        chk("R9", "stamp not advanced while off", seq_o, s0 + 32'd1);

        // ---- restart mid-period (R10)
        wr_reg(A_RATE, 32'd3);
        wait_sig(1'b0, 1'b1, 1000, n);
        repeat (100) @(negedge clk);
        wr_reg(A_RATE, 32'd3);
        wait_sig(1'b0, 1'b1, 1000, n);
        chk("R10", "full period after rewrite", n, 250);
        idx = 1;
        while (!dv_o && idx < 20) begin
            wait_sig(1'b0, 1'b0, 1000, n);
            idx++;
        end
        chk("R10", "rate count restarted", idx, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule